// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt Unit

This unit holds six alarm registers, one for each calendar field (seconds, minutes, hours, date, month, weekday). It compares the enabled registers with the running BCD time whenever the timekeeper signals that a new second has begun. When every enabled field equals the present time, a sticky alarm flag is set and the active-low interrupt line is pulled low.

Two interrupt styles are available. In latched style the line stays low for as long as the flag is set. In pulsed style each match drives the line low for a fixed number of clock cycles, and every later match does so again, so the alarm repeats. The flag can be cleared by software writing zero to it. If the auto-clear control bit is set, reading the status register also clears it. The interrupt output models an open-drain pin: a 0 pulls the line low and a 1 releases it.

Top module: `alarm_match_irq`

## Requirements
- R1: Each alarm register (address 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday) uses bit 7 as its enable and bits 6:0 as the BCD value. An enabled field matches when its bits 6:0 equal bits 6:0 of the present-time input. A disabled field always matches.
- R2: The compare is evaluated only in a cycle with `tick_1s` high, using the time inputs in that cycle. These show the second just entered, so an alarm whose seconds field is 00 fires on the 59-to-00 rollover. A match sets the flag in the following cycle.
- R3: When all six enable bits are 0, no alarm is raised.
- R4: The flag (status register, address 7, bit 0) is sticky. Writing address 7 with bit 0 = 0 clears it, and writing bit 0 = 1 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R5: With control register (address 6) bit 7 = 1, a read of address 7 returns the flag and then clears it in the following cycle. With bit 7 = 0, reads leave the flag unchanged.
- R6: With control bit 6 = 0 (latched style), `irq_n` is 0 exactly while the flag is set.
- R7: With control bit 6 = 1 (pulsed style), each match drives `irq_n` to 0 for exactly PULSE_CYCLES cycles, starting the cycle after the tick. The flag stays set. Every later match starts a new pulse of full length.
- R8: All eight registers read back what was written (status reads as {7'b0, flag}). All registers are 0 after reset, with `irq_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle strobe when a new second begins |
| now_sec | input | 8 | Present seconds, BCD |
| now_min | input | 8 | Present minutes, BCD |
| now_hour | input | 8 | Present hours, BCD |
| now_date | input | 8 | Present date, BCD |
| now_month | input | 8 | Present month, BCD |
| now_wday | input | 8 | Present weekday |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| alm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt, open-drain style |

## Verification
The assertions assume that `tick_1s` is a single-cycle strobe and that the time inputs are stable in the cycle it is high. They also assume that software does not rewrite the control register in the cycle after a match, because the pulse check relies on the mode staying unchanged. The bench raises the tick for one cycle per simulated second and changes time, control and register values only in cycles away from a tick. It sweeps every non-empty enable mask against single-field mismatches, and checks pulse lengths with a short PULSE_CYCLES.

// File: rtl/alarm_match_irq.sv
module alarm_match_irq #(
  parameter int PULSE_CYCLES = 31_250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1s,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_date,
  input  logic [7:0] now_month,
  input  logic [7:0] now_wday,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       alm_flag,
  output logic       irq_n
);
  localparam int NF = 6;
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [2:0] A_CTRL = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;

  logic [7:0]    alarm_r [NF];
  logic [7:0]    ctrl_r;
  logic [7:0]    now_f [NF];
  logic [NF-1:0] fld_ok, fld_en;
  logic [CW-1:0] cnt;

  assign now_f[0] = now_sec;
  assign now_f[1] = now_min;
  assign now_f[2] = now_hour;
  assign now_f[3] = now_date;
  assign now_f[4] = now_month;
  assign now_f[5] = now_wday;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign fld_en[i] = alarm_r[i][7];
    assign fld_ok[i] = !alarm_r[i][7] || (alarm_r[i][6:0] == now_f[i][6:0]);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) alarm_r[i] <= '0;
      else if (wr_en && wr_addr == 3'(i)) alarm_r[i] <= wr_data;
  end

  wire hit    = tick_1s && (|fld_en) && (&fld_ok);
  wire auto   = ctrl_r[7];
  wire pulsed = ctrl_r[6];
  wire clr_wr = wr_en && wr_addr == A_STAT && !wr_data[0];
  wire clr_rd = rd_en && rd_addr == A_STAT && auto;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_r <= '0;
    else if (wr_en && wr_addr == A_CTRL) ctrl_r <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) alm_flag <= 1'b0;
    else if (hit) alm_flag <= 1'b1;
    else if (clr_wr || clr_rd) alm_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (hit) cnt <= CW'(PULSE_CYCLES);
    else if (cnt != 0) cnt <= cnt - 1'b1;

  assign irq_n = pulsed ? (cnt == 0) : !alm_flag;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_r;
      A_STAT:  rd_data = {7'b0, alm_flag};
      default: rd_data = alarm_r[rd_addr];
    endcase
  end

  assert_set_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> $past(tick_1s));
  assert_no_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && fld_en == '0 && !alm_flag) |=> !alm_flag);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !clr_wr && !clr_rd) |=> alm_flag);
  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pulsed && !wr_en) |=> (!irq_n && alm_flag));
  assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PULSE_CYCLES));
endmodule

// File: tb/tb_alarm_match_irq.sv
module tb_alarm_match_irq;
  localparam int PW = 5;
  logic clk = 0, rst_n = 0, tick_1s = 0, wr_en = 0, rd_en = 0;
  logic [7:0] now [6];
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic alm_flag, irq_n;
  int n_chk = 0, n_bad = 0;
  logic [7:0] T [6];

  always #4 clk = ~clk;

  alarm_match_irq #(.PULSE_CYCLES(PW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s),
    .now_sec(now[0]), .now_min(now[1]), .now_hour(now[2]),
    .now_date(now[3]), .now_month(now[4]), .now_wday(now[5]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .alm_flag(alm_flag), .irq_n(irq_n));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic tick_at(input logic [7:0] t [6]);
    for (int i = 0; i < 6; i++) now[i] = t[i];
    tick_1s = 1;
    @(negedge clk); tick_1s = 0;
  endtask

  task automatic set_alarm(input logic [7:0] t [6], input logic [5:0] m);
    for (int i = 0; i < 6; i++) wreg(3'(i), {m[i], t[i][6:0]});
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] t2 [6];
    for (int i = 0; i < 6; i++) now[i] = 0;
    T = '{8'h00, 8'h30, 8'h11, 8'h01, 8'h01, 8'h03};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk(alm_flag, 0, "R8 reset flag");
    chk(irq_n, 1, "R8 reset irq");
    for (int a = 0; a < 8; a++) begin rreg(3'(a), d); chk(d, 0, "R8 reset reg"); end
    // R8 readback
    for (int a = 0; a < 7; a++) begin
      wreg(3'(a), 8'(8'h5A + a * 17)); rreg(3'(a), d); chk(d, 8'(8'h5A + a * 17), "R8 readback");
    end
    wreg(6, 8'h00);
    // R1 sweep: every nonzero mask, single-field mismatches
    for (int m = 1; m < 64; m++) begin
      set_alarm(T, 6'(m));
      for (int f = -1; f < 6; f++) begin
        t2 = T;
        if (f >= 0) t2[f] = {1'b0, t2[f][6:0] ^ 7'h01};
        tick_at(t2);
        chk(alm_flag, (f < 0 || !m[f]) ? 1 : 0, "R1 masked compare");
        wreg(7, 8'h00);
      end
    end
    // R1 time bit 7 ignored
    set_alarm(T, 6'h3F);
    t2 = T; t2[5] = 8'h83; tick_at(t2);
    chk(alm_flag, 1, "R1 bit7 ignored"); wreg(7, 0);
    // R3 no enables
    set_alarm(T, 6'h00);
    tick_at(T); chk(alm_flag, 0, "R3 no enable"); chk(irq_n, 1, "R3 irq");
    // R2 rollover example and tick gating
    set_alarm(T, 6'h1F);
    t2 = T; t2[0] = 8'h59; t2[1] = 8'h29; tick_at(t2);
    chk(alm_flag, 0, "R2 at :59");
    for (int i = 0; i < 6; i++) now[i] = T[i];
    repeat (3) @(negedge clk);
    chk(alm_flag, 0, "R2 no tick no alarm");
    tick_at(T); chk(alm_flag, 1, "R2 rollover fires");
    // R6 latched irq
    repeat (10) @(negedge clk);
    chk(alm_flag, 1, "R4 sticky"); chk(irq_n, 0, "R6 held low");
    wreg(7, 8'h01); chk(alm_flag, 1, "R4 write one no effect");
    rreg(7, d); chk(d, 1, "R5 read no autoclear"); chk(alm_flag, 1, "R5 flag kept");
    wreg(7, 8'h00); chk(alm_flag, 0, "R4 write zero clears"); chk(irq_n, 1, "R6 released");
    wreg(7, 8'h01); chk(alm_flag, 0, "R4 write one no set");
    // R4 set wins over clear
    for (int i = 0; i < 6; i++) now[i] = T[i];
    wr_en = 1; wr_addr = 7; wr_data = 0; tick_1s = 1;
    @(negedge clk); wr_en = 0; tick_1s = 0;
    chk(alm_flag, 1, "R4 match beats clear");
    // R5 auto clear
    wreg(6, 8'h80);
    rreg(7, d); chk(d, 1, "R5 read returns flag");
    chk(alm_flag, 0, "R5 autoclear"); chk(irq_n, 1, "R5 irq released");
    rreg(7, d); chk(d, 0, "R5 second read");
    // R7 pulsed, seconds-only recurring alarm
    wreg(6, 8'h40);
    set_alarm(T, 6'h01);
    for (int rep = 0; rep < 3; rep++) begin
      t2 = T; t2[1] = 8'(rep); tick_at(t2);
      for (int k = 0; k <= PW + 1; k++) begin
        chk(irq_n, (k < PW) ? 0 : 1, "R7 pulse width");
        chk(alm_flag, 1, "R7 flag sticky");
        @(negedge clk);
      end
      wreg(7, 0);
    end
    // R7 retrigger mid pulse
    tick_at(T); @(negedge clk); @(negedge clk);
    tick_at(T);
    for (int k = 0; k <= PW; k++) begin
      chk(irq_n, (k < PW) ? 0 : 1, "R7 retrigger full length");
      @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule